// File: doc/BRIEF.md
# Background Memory Scrubber with Programmable Interval

This block walks a region of an error-corrected SRAM in the background and repairs it one row at a time. A free-running interval timer requests a step every `cfg_interval` clock cycles. Each step reads one row through the shared memory port and hands the stored codeword to an external codec. If the codec reports a correctable error, the corrected codeword is written back to the same row. If it reports an uncorrectable error, the row is left untouched and a one-cycle event carrying the row address goes to the fault-handling logic. Two counters report how many rows were repaired and how many could not be repaired.

The memory port is a valid/ready request channel shared with the processor. The scrubber raises `mem_req` and the arbiter answers with `mem_gnt`, which it holds low whenever the processor owns the port. Once raised, a request keeps its address, direction and write data stable until a cycle in which `mem_req` and `mem_gnt` are both high. Read data is returned on `mem_rdata` in the cycle after the read is granted. A step that has been requested is never dropped, and at most one request is held. A larger interval costs fewer memory cycles but gives errors more time to pile up in a row.

The codec is combinational and sits outside the block. The scrubber drives `chk_word`, and the codec answers on `chk_fixed`, `chk_single` and `chk_double` in the same cycle.

Top module: `scrub_engine`

## Requirements
- R1: While reset is held and after its release, `mem_req` and `err_valid` are low and both counters read zero.
- R2: While enabled and with the port free, successive scrub reads are granted exactly `cfg_interval` cycles apart, for intervals of 8 or more.
- R3: The first step after enable reads row `cfg_base`. Each later step reads the next row, and after `cfg_base+cfg_length-1` the walk wraps back to `cfg_base`.
- R4: When the codec flags `chk_single` for a row, the scrubber writes `chk_fixed` back to that same row and increments `fixed_cnt` by one.
- R5: When the codec flags `chk_double`, the row is not written. `err_valid` pulses high for exactly one cycle with `err_addr` set to the row, and `fatal_cnt` increments by one.
- R6: A row with neither flag set causes no write and leaves both counters unchanged.
- R7: The processor has priority. A request held while `mem_gnt` is low keeps its address, direction and data stable, and the step completes after the grant arrives.
- R8: Clearing `cfg_enable` lets a step already in progress run to completion, including any write-back or error event. After that, no new request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Scrubber on; clearing it stops the scrubber after the current step |
| cfg_interval | input | IW | Cycles between step requests |
| cfg_base | input | AW | First row of the region |
| cfg_length | input | AW | Number of rows in the region |
| mem_req | output | 1 | Memory request valid |
| mem_gnt | input | 1 | Memory request ready (low while the processor owns the port) |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Row address |
| mem_wdata | output | CW | Corrected codeword to write |
| mem_rdata | input | CW | Read codeword, valid the cycle after a read grant |
| chk_word | output | CW | Codeword presented to the codec |
| chk_fixed | input | CW | Corrected codeword from the codec |
| chk_single | input | 1 | Codec: correctable error |
| chk_double | input | 1 | Codec: uncorrectable error |
| err_valid | output | 1 | One-cycle uncorrectable-row event |
| err_addr | output | AW | Row address of the event |
| fixed_cnt | output | CNT_W | Rows repaired |
| fatal_cnt | output | CNT_W | Uncorrectable rows seen |

## Verification
In the bench, the codec marks a codeword as correctable when its top two bits are 01, and its corrected form is the same word with those two bits cleared. Top bits 11 mark a codeword as uncorrectable, and any other value is clean. One region mixes clean, correctable and uncorrectable rows and is walked past its wrap point with the port free. This separates write-back from error reporting and shows that a row repaired on the first pass reads clean on the second. The same run measures the read spacing against the interval. A second region is walked while the processor holds the port for a long stretch, which shows that the pending step waits and is neither dropped nor repeated. Each run ends by clearing the enable in mid-step, which shows that the step finishes and that no new one starts.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_CHECK,
    ST_WBACK,
    ST_ADV
  } scrub_st_e;
endpackage

// File: rtl/scrub_pacer.sv
module scrub_pacer #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [IW-1:0] interval,
  input  logic          take,
  output logic          pending
);
  logic [IW-1:0] tmr;
  logic          tick;

  // One request every `interval` cycles; an interval of 0 or 1 ticks each cycle.
  assign tick = ({1'b0, tmr} + (IW+1)'(1)) >= {1'b0, interval};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr     <= '0;
      pending <= 1'b0;
    end else if (!enable) begin
      tmr     <= '0;
      pending <= 1'b0;
    end else begin
      tmr     <= tick ? '0 : tmr + IW'(1);
      pending <= tick | (pending & ~take);
    end
  end
endmodule

// File: rtl/scrub_walker.sv
module scrub_walker #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          idle,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] length,
  input  logic          advance,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] last_row;

  assign last_row = (length == '0) ? base : base + length - AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr <= '0;
    else if (!enable && idle)
      addr <= base;
    else if (advance)
      addr <= (addr == last_row) ? base : addr + AW'(1);
  end
endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
  import scrub_pkg::*;
#(
  parameter int AW    = 8,
  parameter int CW    = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             pending,
  input  logic [AW-1:0]    addr,
  output logic             take,
  output logic             advance,
  output logic             idle,
  output logic             mem_req,
  input  logic             mem_gnt,
  output logic             mem_we,
  output logic [CW-1:0]    mem_wdata,
  input  logic [CW-1:0]    mem_rdata,
  output logic [CW-1:0]    chk_word,
  input  logic [CW-1:0]    chk_fixed,
  input  logic             chk_single,
  input  logic             chk_double,
  output logic             err_valid,
  output logic [AW-1:0]    err_addr,
  output logic [CNT_W-1:0] fixed_cnt,
  output logic [CNT_W-1:0] fatal_cnt
);
  scrub_st_e     st, st_nx;
  logic [CW-1:0] row_q, fix_q;

  assign idle      = (st == ST_IDLE);
  assign take      = idle & pending & enable;
  assign advance   = (st == ST_ADV);
  assign mem_req   = (st == ST_WAIT) | (st == ST_WBACK);
  assign mem_we    = (st == ST_WBACK);
  assign mem_wdata = fix_q;
  assign chk_word  = row_q;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (take) st_nx = ST_WAIT;
      ST_WAIT:  if (mem_gnt) st_nx = ST_READ;
      ST_READ:  st_nx = ST_CHECK;
      ST_CHECK: st_nx = (chk_single && !chk_double) ? ST_WBACK : ST_ADV;
      ST_WBACK: if (mem_gnt) st_nx = ST_ADV;
      ST_ADV:   st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      row_q     <= '0;
      fix_q     <= '0;
      err_valid <= 1'b0;
      err_addr  <= '0;
      fixed_cnt <= '0;
      fatal_cnt <= '0;
    end else begin
      st        <= st_nx;
      err_valid <= 1'b0;
      if (st == ST_READ) row_q <= mem_rdata;
      if (st == ST_CHECK) begin
        if (chk_double) begin
          err_valid <= 1'b1;
          err_addr  <= addr;
          fatal_cnt <= fatal_cnt + CNT_W'(1);
        end else if (chk_single) begin
          fix_q     <= chk_fixed;
          fixed_cnt <= fixed_cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/scrub_engine.sv
module scrub_engine #(
  parameter int AW    = 8,
  parameter int CW    = 8,
  parameter int IW    = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic [IW-1:0]    cfg_interval,
  input  logic [AW-1:0]    cfg_base,
  input  logic [AW-1:0]    cfg_length,
  output logic             mem_req,
  input  logic             mem_gnt,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [CW-1:0]    mem_wdata,
  input  logic [CW-1:0]    mem_rdata,
  output logic [CW-1:0]    chk_word,
  input  logic [CW-1:0]    chk_fixed,
  input  logic             chk_single,
  input  logic             chk_double,
  output logic             err_valid,
  output logic [AW-1:0]    err_addr,
  output logic [CNT_W-1:0] fixed_cnt,
  output logic [CNT_W-1:0] fatal_cnt
);
  logic pending, take, advance, idle;

  scrub_pacer #(.IW(IW)) u_pacer (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .interval(cfg_interval),
    .take(take), .pending(pending)
  );

  scrub_walker #(.AW(AW)) u_walker (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .idle(idle),
    .base(cfg_base), .length(cfg_length), .advance(advance), .addr(mem_addr)
  );

  scrub_seq #(.AW(AW), .CW(CW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .pending(pending),
    .addr(mem_addr), .take(take), .advance(advance), .idle(idle),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .chk_word(chk_word),
    .chk_fixed(chk_fixed), .chk_single(chk_single), .chk_double(chk_double),
    .err_valid(err_valid), .err_addr(err_addr),
    .fixed_cnt(fixed_cnt), .fatal_cnt(fatal_cnt)
  );
endmodule

// File: rtl/scrub_engine_chk.sv
module scrub_engine_chk #(
  parameter int AW    = 8,
  parameter int CW    = 8,
  parameter int IW    = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic [IW-1:0]    cfg_interval,
  input logic [AW-1:0]    cfg_base,
  input logic [AW-1:0]    cfg_length,
  input logic             mem_req,
  input logic             mem_gnt,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [CW-1:0]    mem_wdata,
  input logic [CW-1:0]    mem_rdata,
  input logic [CW-1:0]    chk_word,
  input logic [CW-1:0]    chk_fixed,
  input logic             chk_single,
  input logic             chk_double,
  input logic             err_valid,
  input logic [AW-1:0]    err_addr,
  input logic [CNT_W-1:0] fixed_cnt,
  input logic [CNT_W-1:0] fatal_cnt
);
  logic [AW-1:0] last_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_rd <= '0;
    else if (mem_req && mem_gnt && !mem_we) last_rd <= mem_addr;
  end

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> !err_valid);

  p_fatal_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> fatal_cnt == $past(fatal_cnt) + CNT_W'(1));

  p_wb_same_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr == last_rd);

  p_fixed_then_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_cnt != $past(fixed_cnt) |-> mem_req && mem_we);
endmodule

bind scrub_engine scrub_engine_chk #(.AW(AW), .CW(CW), .IW(IW), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/scrub_engine_tb.sv
module scrub_engine_tb;
  localparam int AW = 8, CW = 8, IW = 16, CNT_W = 16;

  typedef struct packed {
    logic [1:0]    kind;   // 0 read, 1 write, 2 error event
    logic [AW-1:0] addr;
    logic [CW-1:0] data;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic cfg_enable = 0;
  logic [IW-1:0] cfg_interval = '0;
  logic [AW-1:0] cfg_base = '0, cfg_length = '0;
  logic mem_req, mem_we, err_valid, chk_single, chk_double;
  logic mem_gnt;
  logic cpu_busy = 0;
  logic [AW-1:0] mem_addr, err_addr;
  logic [CW-1:0] mem_wdata, mem_rdata, chk_word, chk_fixed;
  logic [CNT_W-1:0] fixed_cnt, fatal_cnt;
  logic [CW-1:0] mem [0:(1<<AW)-1];

  int errors = 0, checks = 0, cyc = 0, reads_seen = 0;
  int rd_cyc [0:15];
  item_t expq [$];

  always #10 clk = ~clk;

  scrub_engine #(.AW(AW), .CW(CW), .IW(IW), .CNT_W(CNT_W)) u_dut (.*);

  assign mem_gnt = ~cpu_busy;

  // Memory model: read data one cycle after the read grant.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_gnt) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  // Codec model: top bits 01 correctable, 11 uncorrectable.
  always_comb begin
    chk_single = (chk_word[7:6] == 2'b01);
    chk_double = (chk_word[7:6] == 2'b11);
    chk_fixed  = {2'b00, chk_word[5:0]};
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: computes the expected walk from the memory contents.
  task automatic expect_walk(input int base, input int len, input int k);
    logic [CW-1:0] mdl [0:(1<<AW)-1];
    for (int i = 0; i < (1<<AW); i++) mdl[i] = mem[i];
    for (int i = 0; i < k; i++) begin
      int a;
      a = base + (i % len);
      expq.push_back('{2'd0, AW'(a), '0});
      if (mdl[a][7:6] == 2'b01) begin
        mdl[a] = {2'b00, mdl[a][5:0]};
        expq.push_back('{2'd1, AW'(a), mdl[a]});
      end else if (mdl[a][7:6] == 2'b11) begin
        expq.push_back('{2'd2, AW'(a), '0});
      end
    end
  endtask

  // Monitor: pops expected items as the design produces them.
  always @(negedge clk) begin
    if (rst_n && ((mem_req && mem_gnt) || err_valid)) begin
      item_t got;
      got.kind = err_valid ? 2'd2 : (mem_we ? 2'd1 : 2'd0);
      got.addr = err_valid ? err_addr : mem_addr;
      got.data = (got.kind == 2'd1) ? mem_wdata : '0;
      if (got.kind == 2'd0) begin
        if (reads_seen < 16) rd_cyc[reads_seen] = cyc;
        reads_seen++;
      end
      if (expq.size() == 0) begin
        check(0, "R3/R6/R8 unexpected activity", int'(got.addr), -1);
      end else begin
        item_t e;
        e = expq.pop_front();
        check(got.kind == e.kind, "R3/R4/R5/R6 activity kind", int'(got.kind), int'(e.kind));
        check(got.addr == e.addr, "R3 row address", int'(got.addr), int'(e.addr));
        if (e.kind == 2'd1)
          check(got.data == e.data, "R4 corrected data", int'(got.data), int'(e.data));
      end
    end
  end

  task automatic do_reset();
    rst_n = 0;
    cfg_enable = 0;
    repeat (3) @(negedge clk);
    check(!mem_req && !err_valid, "R1 idle during reset", int'(mem_req), 0);
    rst_n = 1;
    @(negedge clk);
    check(fixed_cnt == 0 && fatal_cnt == 0, "R1 counters cleared", int'(fixed_cnt + fatal_cnt), 0);
    check(!mem_req && !err_valid, "R1 quiet after reset", int'(mem_req), 0);
  endtask

  task automatic run_until(input int k);
    int t = 0;
    while (reads_seen < k && t < 5000) begin
      @(negedge clk);
      t++;
    end
    cfg_enable = 0;        // R8: stop mid-step
    repeat (30) @(negedge clk);
    check(expq.size() == 0, "R8 in-flight step completed", expq.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = CW'(i & 8'h3f);
    do_reset();

    // Run 1: free port, mixed rows, walk past the wrap point.
    mem[5] = 8'h4A;
    mem[7] = 8'hC3;
    cfg_base = 8'd4; cfg_length = 8'd5; cfg_interval = 16'd10;
    reads_seen = 0;
    expect_walk(4, 5, 7);
    @(negedge clk);
    cfg_enable = 1;
    run_until(7);
    for (int i = 1; i < 6; i++)
      check(rd_cyc[i] - rd_cyc[i-1] == 10, "R2 read spacing", rd_cyc[i] - rd_cyc[i-1], 10);
    check(fixed_cnt == 1, "R4 fixed count", int'(fixed_cnt), 1);
    check(fatal_cnt == 1, "R5 fatal count", int'(fatal_cnt), 1);
    check(mem[5] == 8'h0A, "R4 row repaired in memory", int'(mem[5]), 8'h0A);
    check(mem[7] == 8'hC3, "R5 uncorrectable row untouched", int'(mem[7]), 8'hC3);
    check(mem[6] == 8'h06, "R6 clean row untouched", int'(mem[6]), 6);
    check(!mem_req, "R8 no request after disable", int'(mem_req), 0);

    // Run 2: processor holds the port at the start of the walk.
    do_reset();
    mem[8'h11] = 8'h55;
    mem[8'h12] = 8'hD0;
    cfg_base = 8'h10; cfg_length = 8'd3; cfg_interval = 16'd12;
    reads_seen = 0;
    expect_walk(16, 3, 5);
    @(negedge clk);
    cpu_busy = 1;
    cfg_enable = 1;
    repeat (40) @(negedge clk);
    check(reads_seen == 0, "R7 no grant while processor busy", reads_seen, 0);
    check(mem_req && mem_addr == 8'h10, "R7 request held waiting", int'(mem_addr), 16);
    cpu_busy = 0;
    run_until(5);
    check(reads_seen == 5, "R7 step not dropped or repeated", reads_seen, 5);
    check(fixed_cnt == 1, "R4 fixed count run 2", int'(fixed_cnt), 1);
    check(fatal_cnt == 1, "R5 fatal count run 2", int'(fatal_cnt), 1);
    check(mem[8'h11] == 8'h15, "R4 row repaired run 2", int'(mem[8'h11]), 8'h15);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule